// File: doc/BRIEF.md
# Isochronous IN Double-Buffered Endpoint

This block is the transmit half of a device-side isochronous IN endpoint. It holds two packet buffers that take turns. During any frame one buffer is the *send side*, which the host reads through IN tokens. The other buffer is the *fill side*, which firmware loads through a small byte-wide register port. Every start-of-frame swaps the two roles. This gives firmware a full frame to prepare the next packet while the previous one is sent.

Firmware pushes one packet byte by byte into a data register and then sets a request bit, which marks the fill buffer valid. When an IN token arrives, the block streams the send-side bytes one per clock if that buffer is valid. Otherwise it answers with a one-cycle zero-length-packet strobe. The endpoint never refuses a token. A sent buffer is invalidated so its contents cannot go out twice. Each start-of-frame latches the 11-bit frame number, which firmware reads to confirm it is filling for the intended frame. It also raises a start-of-frame flag that drives an interrupt. Flags clear when firmware writes 1 to them.

Top module: `iso_in_pingpong_ep`

## Requirements
- R1: After reset, buffer A is the send side and B the fill side, both are invalid with length 0, the status register (address 2) reads 0, the frame registers read 0, and `tx_valid`, `tx_zlp` and `irq_sof` are low.
- R2: Each cycle with `sof_valid` high swaps the roles. The buffer that was being filled becomes the send side. The buffer that was the send side becomes the fill side with length 0 and not valid, so the fill count (address 5) reads 0 after the swap.
- R3: An `in_token` while idle, with the send side valid and holding N>0 bytes, gives N consecutive cycles of `tx_valid` starting the cycle after the token. The bytes come out in write order, and `tx_last` is high only with the N-th byte.
- R4: An `in_token` while idle, with the send side invalid or valid with length 0, gives a single-cycle `tx_zlp` in the next cycle and no `tx_valid`.
- R5: Starting a transmission invalidates the send buffer, so a further token in the same frame receives a zero-length packet.
- R6: When the last byte of a data packet goes out, status bit 1 (transmit complete) is set in the next cycle. A zero-length packet leaves bit 1 unchanged.
- R7: A start-of-frame sets status bit 0, and `irq_sof` equals that bit. Writing address 2 clears each status bit written as 1, and bits written as 0 are kept.
- R8: A start-of-frame captures `sof_frame[10:0]`: bits 7:0 are readable at address 3 and bits 10:8 at address 4, bits 2:0.
- R9: A write to address 0 appends one byte to the fill buffer and increments its count, which is readable at address 5. When the count already equals DEPTH, the byte is dropped and status bit 2 (overrun) is set.
- R10: Writing address 1 with bit 0 set marks the fill buffer valid. After that, data writes to it are ignored and its count is unchanged until it is recycled.
- R11: A fill buffer that was not marked valid before the next start-of-frame still becomes the send side, but stays invalid, so a token then receives a zero-length packet.
- R12: An `in_token` that arrives while a packet is being streamed is ignored and produces no extra output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 data, 1 control, 2 status, 3 frame low, 4 frame high, 5 fill count) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the addressed register (combinational) |
| sof_valid | input | 1 | Start-of-frame received |
| sof_frame | input | 11 | Frame number carried by the start-of-frame |
| in_token | input | 1 | IN token addressed to this endpoint |
| tx_valid | output | 1 | Data byte valid |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_zlp | output | 1 | Send a zero-length data packet |
| irq_sof | output | 1 | Start-of-frame interrupt |

## Verification
The hardest case to reach is the full-depth packet that ends with an overrun. It needs DEPTH+2 register writes while the buffer is the fill side, then a request, then a swap. Only after that do the 64 captured bytes come back on the token side, and the two dropped bytes must be absent. The bench sets this up with a loop of distinct byte values so that any shift or extra byte shows as a miscompare. It also checks the other reachable corner cases: a token that lands inside a running packet, and a request made with zero bytes.

// File: rtl/iso_ep_pkg.sv
package iso_ep_pkg;

    typedef enum logic [2:0] {
        RA_DATA  = 3'd0,
        RA_CTRL  = 3'd1,
        RA_STAT  = 3'd2,
        RA_FLO   = 3'd3,
        RA_FHI   = 3'd4,
        RA_FCNT  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic ovr;
        logic done;
        logic sof;
    } status_t;

    localparam int FRAME_W = 11;

    function automatic logic [7:0] frame_hi_byte(input logic [FRAME_W-1:0] f);
        return {5'b0, f[10:8]};
    endfunction

    function automatic logic [7:0] status_byte(input status_t s);
        return {5'b0, s};
    endfunction

endpackage

// File: rtl/iso_pkt_buf.sv
module iso_pkt_buf #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_byte,
    input  logic          mark_ready,
    input  logic          recycle,
    input  logic          consume,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_byte,
    output logic [CW-1:0] count,
    output logic          valid,
    output logic          overflow
);

    logic [7:0] mem [DEPTH];
    logic       full;
    logic       accept;

    assign full     = (count == CW'(DEPTH));
    assign accept   = wr_en && !valid && !full;
    assign overflow = wr_en && !valid && full;
    assign rd_byte  = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (accept) begin
            mem[count[IW-1:0]] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            valid <= 1'b0;
        end else if (recycle) begin
            count <= '0;
            valid <= 1'b0;
        end else begin
            if (accept) begin
                count <= count + CW'(1);
            end
            if (consume) begin
                valid <= 1'b0;
            end else if (mark_ready) begin
                valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/iso_tx_engine.sv
module iso_tx_engine #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_token,
    input  logic          send_valid,
    input  logic [CW-1:0] send_len,
    input  logic          send_side,
    output logic          consume,
    output logic          done,
    output logic          rd_side,
    output logic [IW-1:0] rd_idx,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          tx_zlp
);

    logic          busy;
    logic [CW-1:0] idx;
    logic [CW-1:0] len;
    logic          accept_tok;
    logic          has_data;

    assign accept_tok = in_token && !busy;
    assign has_data   = send_valid && (send_len != '0);
    assign consume    = accept_tok && send_valid;
    assign tx_valid   = busy;
    assign tx_last    = busy && (idx == len - CW'(1));
    assign done       = tx_last;
    assign rd_idx     = idx[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            len     <= '0;
            rd_side <= 1'b0;
            tx_zlp  <= 1'b0;
        end else begin
            tx_zlp <= accept_tok && !has_data;
            if (accept_tok && has_data) begin
                busy    <= 1'b1;
                idx     <= '0;
                len     <= send_len;
                rd_side <= send_side;
            end else if (busy) begin
                if (tx_last) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + CW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/iso_status_regs.sv
module iso_status_regs
    import iso_ep_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sof_evt,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               done_evt,
    input  logic               ovr_evt,
    input  logic               clr_wr,
    input  status_t            clr_mask,
    output status_t            status,
    output logic [FRAME_W-1:0] frame
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            frame  <= '0;
        end else begin
            if (sof_evt) begin
                frame <= sof_frame;
            end
            status.sof  <= sof_evt  || (status.sof  && !(clr_wr && clr_mask.sof));
            status.done <= done_evt || (status.done && !(clr_wr && clr_mask.done));
            status.ovr  <= ovr_evt  || (status.ovr  && !(clr_wr && clr_mask.ovr));
        end
    end

endmodule

// File: rtl/iso_in_pingpong_ep.sv
module iso_in_pingpong_ep
    import iso_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        sof_valid,
    input  logic [10:0] sof_frame,
    input  logic        in_token,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        tx_zlp,
    output logic        irq_sof
);

    reg_addr_e      addr;
    logic           send_sel;
    logic           fill_sel;
    logic           data_wr;
    logic           ctrl_req;
    logic           stat_wr;
    logic [7:0]     buf_byte [2];
    logic [CW-1:0]  buf_cnt  [2];
    logic [1:0]     buf_valid;
    logic [1:0]     buf_ovf;
    logic           send_valid;
    logic [CW-1:0]  send_len;
    logic [CW-1:0]  fill_cnt;
    logic           eng_consume;
    logic           eng_done;
    logic           eng_side;
    logic [IW-1:0]  eng_idx;
    status_t        status;
    logic [10:0]    frame_q;

    assign addr     = reg_addr_e'(reg_addr);
    assign fill_sel = ~send_sel;
    assign data_wr  = reg_wr && (addr == RA_DATA);
    assign ctrl_req = reg_wr && (addr == RA_CTRL) && reg_wdata[0];
    assign stat_wr  = reg_wr && (addr == RA_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            send_sel <= 1'b0;
        end else if (sof_valid) begin
            send_sel <= ~send_sel;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_buf
        iso_pkt_buf #(.DEPTH(DEPTH)) u_buf (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (data_wr && (fill_sel == 1'(i))),
            .wr_byte    (reg_wdata),
            .mark_ready (ctrl_req && (fill_sel == 1'(i))),
            .recycle    (sof_valid && (send_sel == 1'(i))),
            .consume    (eng_consume && (send_sel == 1'(i))),
            .rd_idx     (eng_idx),
            .rd_byte    (buf_byte[i]),
            .count      (buf_cnt[i]),
            .valid      (buf_valid[i]),
            .overflow   (buf_ovf[i])
        );
    end

    assign send_valid = buf_valid[send_sel];
    assign send_len   = buf_cnt[send_sel];
    assign fill_cnt   = buf_cnt[fill_sel];

    iso_tx_engine #(.DEPTH(DEPTH)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .in_token   (in_token),
        .send_valid (send_valid),
        .send_len   (send_len),
        .send_side  (send_sel),
        .consume    (eng_consume),
        .done       (eng_done),
        .rd_side    (eng_side),
        .rd_idx     (eng_idx),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_zlp     (tx_zlp)
    );

    assign tx_data = buf_byte[eng_side];

    iso_status_regs u_stat (
        .clk       (clk),
        .rst       (rst),
        .sof_evt   (sof_valid),
        .sof_frame (sof_frame),
        .done_evt  (eng_done),
        .ovr_evt   (|buf_ovf),
        .clr_wr    (stat_wr),
        .clr_mask  (status_t'(reg_wdata[2:0])),
        .status    (status),
        .frame     (frame_q)
    );

    assign irq_sof = status.sof;

    always_comb begin
        case (addr)
            RA_STAT: reg_rdata = status_byte(status);
            RA_FLO:  reg_rdata = frame_q[7:0];
            RA_FHI:  reg_rdata = frame_hi_byte(frame_q);
            RA_FCNT: reg_rdata = 8'(fill_cnt);
            default: reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/iso_ep_chk.sv
module iso_ep_chk #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          sof_valid,
    input logic [10:0]   sof_frame,
    input logic          in_token,
    input logic          tx_valid,
    input logic          tx_last,
    input logic          tx_zlp,
    input logic          irq_sof,
    input logic          send_sel,
    input logic          send_valid,
    input logic [10:0]   frame_q,
    input logic [CW-1:0] fill_cnt
);

    AST_SOF_SWAP: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> (send_sel != $past(send_sel))); // R2

    AST_SOF_RECYCLE: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> (fill_cnt == '0)); // R2

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_last) |=> !tx_valid); // R3

    AST_EMPTY_ZLP: assert property (@(posedge clk) disable iff (rst)
        (in_token && !tx_valid && !send_valid) |=> (tx_zlp && !tx_valid)); // R4

    AST_NO_ZLP_MIDPKT: assert property (@(posedge clk) disable iff (rst)
        !(tx_zlp && tx_valid)); // R12

    AST_SOF_IRQ: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> irq_sof); // R7

    AST_FRAME_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        sof_valid |=> (frame_q == $past(sof_frame))); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        fill_cnt <= CW'(DEPTH)); // R9

endmodule

bind iso_in_pingpong_ep iso_ep_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sof_valid  (sof_valid),
    .sof_frame  (sof_frame),
    .in_token   (in_token),
    .tx_valid   (tx_valid),
    .tx_last    (tx_last),
    .tx_zlp     (tx_zlp),
    .irq_sof    (irq_sof),
    .send_sel   (send_sel),
    .send_valid (send_valid),
    .frame_q    (frame_q),
    .fill_cnt   (fill_cnt)
);

// File: tb/sim_iso_in_pingpong_ep.sv
module sim_iso_in_pingpong_ep;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = 11'd0;
    logic        in_token = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_zlp;
    logic        irq_sof;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct {
        bit         zlp;
        logic [7:0] d;
        bit         last;
        string      tag;
    } exp_t;

    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    iso_in_pingpong_ep #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sof_valid(sof_valid),
        .sof_frame(sof_frame), .in_token(in_token), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_last(tx_last), .tx_zlp(tx_zlp), .irq_sof(irq_sof)
    );

    task automatic chk(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // monitor: pop expected items as the design emits them
    always @(negedge clk) begin
        if (!rst && (tx_valid || tx_zlp)) begin
            if (expq.size() == 0) begin
                vectors++;
                fails++;
                $display("FAIL unexpected output: actual valid=%0b zlp=%0b expected none (R12)",
                         tx_valid, tx_zlp);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk({e.tag, " zlp"}, int'(tx_zlp), int'(e.zlp));
                if (!e.zlp) begin
                    chk({e.tag, " data"}, int'(tx_data), int'(e.d));
                    chk({e.tag, " last"}, int'(tx_last), int'(e.last));
                end else begin
                    chk({e.tag, " no data with zlp"}, int'(tx_valid), 0);
                end
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(logic [2:0] a, int exp, string tag);
        reg_addr = a;
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic sof(logic [10:0] f);
        sof_valid = 1'b1; sof_frame = f;
        tick(1);
        sof_valid = 1'b0;
    endtask

    task automatic token();
        in_token = 1'b1;
        tick(1);
        in_token = 1'b0;
    endtask

    task automatic push_zlp(string tag);
        exp_t e;
        e.zlp = 1; e.d = 8'h00; e.last = 0; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic push_byte(logic [7:0] d, bit last, string tag);
        exp_t e;
        e.zlp = 0; e.d = d; e.last = last; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic drain_chk(string tag);
        chk({tag, " queue drained"}, expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        rd_chk(3'd2, 0, "R1 status");
        rd_chk(3'd3, 0, "R1 frame lo");
        rd_chk(3'd4, 0, "R1 frame hi");
        rd_chk(3'd5, 0, "R1 fill count");
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 irq", int'(irq_sof), 0);

        // R4 token with nothing ready
        push_zlp("R4 empty");
        token();
        tick(3);
        drain_chk("R4");
        rd_chk(3'd2, 0, "R6 zlp leaves done clear");

        // R9 / R10 fill B with 5 bytes, mark, extra write ignored
        for (int i = 0; i < 5; i++) wr(3'd0, 8'(8'h10 + i));
        rd_chk(3'd5, 5, "R9 count");
        wr(3'd1, 8'h01);
        wr(3'd0, 8'hEE);
        rd_chk(3'd5, 5, "R10 write after ready ignored");

        // R8 / R7 / R2 SOF
        sof(11'h5A3);
        rd_chk(3'd3, 8'hA3, "R8 frame lo");
        rd_chk(3'd4, 8'h05, "R8 frame hi");
        rd_chk(3'd2, 1, "R7 sof flag");
        chk("R7 irq", int'(irq_sof), 1);
        rd_chk(3'd5, 0, "R2 new fill empty");

        // R3 stream 5 bytes, R12 token mid-packet ignored
        for (int i = 0; i < 5; i++) push_byte(8'(8'h10 + i), i == 4, "R3 packet");
        token();
        in_token = 1'b1;
        tick(1);
        in_token = 1'b0;
        tick(8);
        drain_chk("R3/R12");
        rd_chk(3'd2, 3, "R6 done flag");

        // R5 second token same frame
        push_zlp("R5 resend blocked");
        token();
        tick(3);
        drain_chk("R5");

        // R7 write-one-to-clear
        wr(3'd2, 8'h00);
        rd_chk(3'd2, 3, "R7 zero write keeps");
        wr(3'd2, 8'h01);
        rd_chk(3'd2, 2, "R7 clear sof");
        chk("R7 irq low", int'(irq_sof), 0);
        wr(3'd2, 8'h02);
        rd_chk(3'd2, 0, "R6 clear done");

        // R11 unmarked fill still swaps in invalid
        for (int i = 0; i < 3; i++) wr(3'd0, 8'(8'hA0 + i));
        rd_chk(3'd5, 3, "R9 count A");
        sof(11'h001);
        rd_chk(3'd5, 0, "R2 recycled fill");
        push_zlp("R11 unmarked");
        token();
        tick(3);
        drain_chk("R11");

        // R9 overrun at DEPTH, full-depth packet
        for (int i = 0; i < DEPTH + 2; i++) wr(3'd0, 8'(i) ^ 8'h3C);
        rd_chk(3'd5, DEPTH, "R9 count saturates");
        rd_chk(3'd2, 5, "R9 overrun flag");
        wr(3'd1, 8'h01);
        sof(11'h002);
        for (int i = 0; i < DEPTH; i++) push_byte(8'(i) ^ 8'h3C, i == DEPTH - 1, "R3 full depth");
        token();
        tick(DEPTH + 4);
        drain_chk("R3 full");

        // R4 valid but zero length
        wr(3'd2, 8'h07);
        rd_chk(3'd5, 0, "R2 fill empty");
        wr(3'd1, 8'h01);
        sof(11'h003);
        push_zlp("R4 zero length");
        token();
        tick(3);
        drain_chk("R4 zero");
        rd_chk(3'd2, 1, "R6 zlp no done");

        finished = 1;
        report();
    end

endmodule